// File: doc/BRIEF.md
# Timestamp Reconstruction Unit

Event timestamps arrive as a short partial value: only the low `PART_W` bits of a free-running tick counter (24 bits by default, with one tick of 8 ns, so the field wraps roughly every 134 ms). This block turns such a partial value back into a full `TS_W`-bit time. It pairs the value with a complete sample of the same counter. That sample must have been read after the event and no more than one wrap period later.

The result keeps the sample's upper bits and takes the partial value as its low bits. If the partial value is numerically larger than the sample's low bits, the counter wrapped between the event and the sample, and one wrap (2^`PART_W` ticks) is taken off. The same test also shows why a sample read before the event is wrong. In that case the partial value usually exceeds the sample's low bits, a wrap is wrongly assumed, and the result lands exactly one wrap period early.

The two inputs may arrive in either order or together. Whichever comes first is held until its partner arrives. The finished timestamp then appears for a single cycle after a two-register pipeline. The reset input is asynchronous and active-low, and it is released synchronously inside the block.

Top module: `ts_rebuild`

## Requirements
- R1: While reset is asserted, and in the first sampled cycle after its release, `out_vld`, `out_clamped` and `overrun` are all low.
- R2: When the partial value is less than or equal to the sample's low `PART_W` bits, `out_ts` equals the sample with its low `PART_W` bits replaced by the partial value. With equal low bits, `out_ts` equals the sample itself.
- R3: When the partial value is greater than the sample's low `PART_W` bits and the sample's upper bits are non-zero, `out_ts` equals the spliced value minus 2^`PART_W`.
- R4: When a wrap correction is needed but the sample's upper bits are all zero, `out_ts` is zero and `out_clamped` is 1 in the same cycle as `out_vld`. Otherwise `out_clamped` is 0 while `out_vld` is high.
- R5: If the later of the two inputs is sampled at clock edge k, then `out_vld` is high in the cycle following edge k+1. This latency is the same for partial-first, sample-first and simultaneous arrival.
- R6: Each completed pair produces exactly one `out_vld` cycle. A lone partial value or a lone sample produces no output for as long as it waits.
- R7: A partial value that arrives while an earlier one is still waiting raises `overrun` for one cycle, in the cycle after its edge. The newer value replaces the older one and is the one used.
- R8: A sample that arrives while an earlier sample is still waiting replaces it without raising `overrun`. The newer sample is the one used.
- R9: A sample read before the event, within one wrap period and with a larger low part, yields a result exactly 2^`PART_W` ticks below the true event time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| part_vld | input | 1 | Partial timestamp strobe |
| part_ts | input | PART_W | Low bits of the counter at the event |
| smp_vld | input | 1 | Full counter sample strobe |
| smp_ts | input | TS_W | Full counter value read after the event |
| out_vld | output | 1 | One-cycle strobe for a rebuilt timestamp |
| out_ts | output | TS_W | Rebuilt timestamp |
| out_clamped | output | 1 | Result was floored to zero instead of underflowing |
| overrun | output | 1 | A waiting partial value was replaced |

## Verification
The bench builds the block with `PART_W` = 4 and `TS_W` = 8. At that size every combination of partial value and counter sample (4096 pairs) can be swept with simultaneous arrival. That sweep reaches every wrap boundary, every equal-low-bits case and every clamp case. A thinned grid of the same space is then replayed with the partial value first and with the sample first, followed by random pairs in random order. Directed sequences cover overrun, sample replacement, lone inputs and the early-sample error, each against expected values that the bench computes arithmetically.

// File: rtl/ts_rebuild_pkg.sv
package ts_rebuild_pkg;

  // How the merge stage formed the result
  typedef enum logic [1:0] {
    MK_SPLICE = 2'd0,  // no wrap between event and sample
    MK_BORROW = 2'd1,  // one wrap removed from the upper part
    MK_FLOOR  = 2'd2   // wrap needed but upper part is zero
  } merge_kind_e;

endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ts_pair_hold.sv
module ts_pair_hold #(
  parameter int PART_W = 24,
  parameter int TS_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_vld,
  input  logic [PART_W-1:0] part_ts,
  input  logic              smp_vld,
  input  logic [TS_W-1:0]   smp_ts,
  output logic              pair_vld,
  output logic [PART_W-1:0] pair_part,
  output logic [TS_W-1:0]   pair_smp,
  output logic              ovr
);

  logic              part_pend_q, part_pend_d;
  logic [PART_W-1:0] part_q;
  logic              smp_pend_q, smp_pend_d;
  logic [TS_W-1:0]   smp_q;
  logic              pair_vld_q, pair_vld_d;
  logic [PART_W-1:0] pair_part_q, pair_part_d;
  logic [TS_W-1:0]   pair_smp_q, pair_smp_d;
  logic              ovr_q, ovr_d;
  logic              have_part, have_smp, fire;

  // next-state
  always_comb begin
    have_part   = part_vld | part_pend_q;
    have_smp    = smp_vld | smp_pend_q;
    fire        = have_part & have_smp;
    part_pend_d = have_part & ~fire;
    smp_pend_d  = have_smp & ~fire;
    pair_vld_d  = fire;
    pair_part_d = part_vld ? part_ts : part_q;
    pair_smp_d  = smp_vld ? smp_ts : smp_q;
    ovr_d       = part_vld & part_pend_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_pend_q <= 1'b0;
      smp_pend_q  <= 1'b0;
      pair_vld_q  <= 1'b0;
      ovr_q       <= 1'b0;
    end else begin
      part_pend_q <= part_pend_d;
      smp_pend_q  <= smp_pend_d;
      pair_vld_q  <= pair_vld_d;
      ovr_q       <= ovr_d;
    end
  end

  // data registers with clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q      <= '0;
      smp_q       <= '0;
      pair_part_q <= '0;
      pair_smp_q  <= '0;
    end else begin
      if (part_vld) part_q <= part_ts;
      if (smp_vld)  smp_q  <= smp_ts;
      if (fire) begin
        pair_part_q <= pair_part_d;
        pair_smp_q  <= pair_smp_d;
      end
    end
  end

  assign pair_vld  = pair_vld_q;
  assign pair_part = pair_part_q;
  assign pair_smp  = pair_smp_q;
  assign ovr       = ovr_q;

  AST_PAIR_NEEDS_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_q |-> ($past(part_vld) || $past(part_pend_q)) && ($past(smp_vld) || $past(smp_pend_q))); // R6
  AST_OVR_ONLY_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> $past(part_vld) && $past(part_pend_q)); // R7
  AST_PAIR_USES_NEW_PART: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_q && $past(part_vld) |-> pair_part_q == $past(part_ts)); // R7
  AST_PAIR_USES_NEW_SMP: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_q && $past(smp_vld) |-> pair_smp_q == $past(smp_ts)); // R8

endmodule

// File: rtl/ts_merge.sv
module ts_merge
  import ts_rebuild_pkg::*;
#(
  parameter int PART_W = 24,
  parameter int TS_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_vld,
  input  logic [PART_W-1:0] pair_part,
  input  logic [TS_W-1:0]   pair_smp,
  output logic              res_vld,
  output logic [TS_W-1:0]   res_ts,
  output logic              res_clamped
);

  localparam int UP_W = TS_W - PART_W;

  logic [UP_W-1:0]   upper;
  logic [PART_W-1:0] low;
  merge_kind_e       kind;
  logic [TS_W-1:0]   res_d, res_q;
  logic              clamp_d, clamp_q;
  logic              vld_q;

  // next-state
  always_comb begin
    upper = pair_smp[TS_W-1:PART_W];
    low   = pair_smp[PART_W-1:0];
    if (pair_part <= low)    kind = MK_SPLICE;
    else if (upper != '0)    kind = MK_BORROW;
    else                     kind = MK_FLOOR;
    case (kind)
      MK_SPLICE: res_d = {upper, pair_part};
      MK_BORROW: res_d = {upper - UP_W'(1), pair_part};
      default:   res_d = '0;
    endcase
    clamp_d = (kind == MK_FLOOR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      clamp_q <= 1'b0;
    end else begin
      vld_q <= pair_vld;
      if (pair_vld) begin
        res_q   <= res_d;
        clamp_q <= clamp_d;
      end
    end
  end

  assign res_vld     = vld_q;
  assign res_ts      = res_q;
  assign res_clamped = clamp_q;

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !vld_q && !clamp_q); // R1
  AST_FOLLOWS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(pair_vld)); // R5
  AST_LOW_FROM_PART: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !clamp_q |-> res_q[PART_W-1:0] == $past(pair_part)); // R2
  AST_NOT_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> res_q <= $past(pair_smp)); // R3
  AST_FLOOR_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && clamp_q |-> res_q == '0); // R4

endmodule

// File: rtl/ts_rebuild.sv
module ts_rebuild #(
  parameter int PART_W = 24,
  parameter int TS_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_vld,
  input  logic [PART_W-1:0] part_ts,
  input  logic              smp_vld,
  input  logic [TS_W-1:0]   smp_ts,
  output logic              out_vld,
  output logic [TS_W-1:0]   out_ts,
  output logic              out_clamped,
  output logic              overrun
);

  logic              rst_n_i;
  logic              pair_vld;
  logic [PART_W-1:0] pair_part;
  logic [TS_W-1:0]   pair_smp;

  ts_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ts_pair_hold #(.PART_W(PART_W), .TS_W(TS_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .part_vld  (part_vld),
    .part_ts   (part_ts),
    .smp_vld   (smp_vld),
    .smp_ts    (smp_ts),
    .pair_vld  (pair_vld),
    .pair_part (pair_part),
    .pair_smp  (pair_smp),
    .ovr       (overrun)
  );

  ts_merge #(.PART_W(PART_W), .TS_W(TS_W)) i_merge (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .pair_vld    (pair_vld),
    .pair_part   (pair_part),
    .pair_smp    (pair_smp),
    .res_vld     (out_vld),
    .res_ts      (out_ts),
    .res_clamped (out_clamped)
  );

  AST_OVR_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n_i |-> !overrun); // R1

endmodule

// File: tb/test_ts_rebuild.sv
module test_ts_rebuild;

  localparam int PW = 4;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          part_vld = 1'b0;
  logic [PW-1:0] part_ts = '0;
  logic          smp_vld = 1'b0;
  logic [TW-1:0] smp_ts = '0;
  logic          out_vld;
  logic [TW-1:0] out_ts;
  logic          out_clamped;
  logic          overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ts_rebuild #(.PART_W(PW), .TS_W(TW)) i_ts_rebuild (
    .clk(clk), .rst_n(rst_n),
    .part_vld(part_vld), .part_ts(part_ts),
    .smp_vld(smp_vld), .smp_ts(smp_ts),
    .out_vld(out_vld), .out_ts(out_ts),
    .out_clamped(out_clamped), .overrun(overrun)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model straight from R2..R4
  function automatic logic [TW:0] ref_of(logic [PW-1:0] p, logic [TW-1:0] s);
    int up, res;
    up = int'(s) >> PW;
    res = (up << PW) | int'(p);
    if (int'(p) > (int'(s) & ((1 << PW) - 1))) begin
      if (up == 0) return {1'b1, {TW{1'b0}}};
      res = res - (1 << PW);
    end
    return {1'b0, TW'(res)};
  endfunction

  // called at a negedge; order 0 together, 1 partial first, 2 sample first
  task automatic run_pair(logic [PW-1:0] p, logic [TW-1:0] s, int order);
    logic [TW:0] e;
    e = ref_of(p, s);
    if (order == 0) begin
      part_vld = 1; part_ts = p; smp_vld = 1; smp_ts = s;
      @(negedge clk); part_vld = 0; smp_vld = 0;
    end else begin
      if (order == 1) begin part_vld = 1; part_ts = p; end
      else            begin smp_vld = 1; smp_ts = s; end
      @(negedge clk); part_vld = 0; smp_vld = 0;
      @(negedge clk);
      chk(!out_vld, "R6 lone input no output", longint'(out_vld), 0);
      if (order == 1) begin smp_vld = 1; smp_ts = s; end
      else            begin part_vld = 1; part_ts = p; end
      @(negedge clk); part_vld = 0; smp_vld = 0;
    end
    @(negedge clk);
    chk(out_vld, "R5 out_vld latency", longint'(out_vld), 1);
    if (p <= s[PW-1:0])
      chk(out_ts == e[TW-1:0], "R2 splice", longint'(out_ts), longint'(e[TW-1:0]));
    else if (e[TW])
      chk(out_ts == '0, "R4 floor to zero", longint'(out_ts), 0);
    else
      chk(out_ts == e[TW-1:0], "R3 wrap borrow", longint'(out_ts), longint'(e[TW-1:0]));
    chk(out_clamped == e[TW], "R4 clamp flag", longint'(out_clamped), longint'(e[TW]));
    @(negedge clk);
    chk(!out_vld, "R6 single pulse", longint'(out_vld), 0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 120000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_vld && !out_clamped && !overrun, "R1 outputs low in reset",
        longint'({out_vld, out_clamped, overrun}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_vld && !out_clamped && !overrun, "R1 outputs low after release",
        longint'({out_vld, out_clamped, overrun}), 0);
    repeat (3) @(negedge clk);

    // exhaustive sweep, simultaneous arrival (R2 R3 R4 R5 R6)
    for (int s = 0; s < (1 << TW); s++)
      for (int p = 0; p < (1 << PW); p++)
        run_pair(PW'(p), TW'(s), 0);

    // thinned grid in both orders
    for (int s = 0; s < (1 << TW); s += 7)
      for (int p = 0; p < (1 << PW); p++) begin
        run_pair(PW'(p), TW'(s), 1);
        run_pair(PW'(p), TW'(s), 2);
      end

    // random pairs, random order
    for (int n = 0; n < 300; n++)
      run_pair(PW'($urandom), TW'($urandom), int'($urandom % 3));

    // R7: overrun replaces the waiting partial value
    part_vld = 1; part_ts = 4'h9;
    @(negedge clk); part_ts = 4'h3;
    @(negedge clk); part_vld = 0;
    chk(overrun, "R7 overrun raised", longint'(overrun), 1);
    @(negedge clk);
    chk(!overrun, "R7 overrun one cycle", longint'(overrun), 0);
    smp_vld = 1; smp_ts = 8'h57;
    @(negedge clk); smp_vld = 0;
    @(negedge clk);
    chk(out_vld && out_ts == 8'h53, "R7 newer partial used", longint'(out_ts), 'h53);
    @(negedge clk);

    // R8: newer sample replaces the waiting one without overrun
    smp_vld = 1; smp_ts = 8'h28;
    @(negedge clk); smp_ts = 8'h6C;
    @(negedge clk); smp_vld = 0;
    chk(!overrun, "R8 no overrun on sample replace", longint'(overrun), 0);
    part_vld = 1; part_ts = 4'hA;
    @(negedge clk); part_vld = 0;
    @(negedge clk);
    chk(out_vld && out_ts == 8'h6A, "R8 newer sample used", longint'(out_ts), 'h6A);
    @(negedge clk);

    // R6: a lone sample waits many cycles with no output
    smp_vld = 1; smp_ts = 8'h11;
    @(negedge clk); smp_vld = 0;
    for (int w = 0; w < 20; w++) begin
      if (out_vld) chk(1'b0, "R6 lone sample output", 1, 0);
      @(negedge clk);
    end
    chk(!out_vld, "R6 lone sample no output", longint'(out_vld), 0);
    part_vld = 1; part_ts = 4'h1;
    @(negedge clk); part_vld = 0;
    @(negedge clk);
    chk(out_vld && out_ts == 8'h11, "R2 equal low bits after wait", longint'(out_ts), 'h11);
    @(negedge clk);

    // R9: event at 0x35; early sample 0x33 gives 0x25, late samples give 0x35
    run_pair(4'h5, 8'h33, 0);
    chk(out_ts == 8'h35 - 8'h10, "R9 early sample off by one wrap", longint'(out_ts), 'h25);
    run_pair(4'h5, 8'h3A, 1);
    chk(out_ts == 8'h35, "R9 later sample correct", longint'(out_ts), 'h35);
    run_pair(4'h5, 8'h42, 2);
    chk(out_ts == 8'h35, "R9 sample after wrap correct", longint'(out_ts), 'h35);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule